// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital front end that sets a 6-bit step attenuator. It produces an attenuation word in half-decibel units: the top bit is worth 16 dB, the next 8 dB, then 4, 2 and 1 dB, and the bottom bit 0.5 dB. A word of all zeros selects the reference-loss state and a word of all ones selects 31.5 dB. The word can come from six parallel pins or from a serial shift register. A mode pin chooses the source. A latch-enable pin decides whether the output follows that source or holds its value.

The serial clock, serial data and latch-enable pins are asynchronous. They are brought into one fast system clock through two-stage synchronisers, and serial shifting happens on the detected rising edge of the serial clock. The most significant bit is shifted in first. The register's top stage drives a serial output, so several devices can share one data line in a chain.

Power-up is a synchronous, active-low reset. While reset is held, the output is loaded with a defined start word. In serial mode that word is the value on the parallel pins. In parallel mode with the latch enable high, it is also the value on the parallel pins. In parallel mode with the latch enable low, it is one of four fixed words picked by two select pins.

Top module: `atten_ctl_top`

## Requirements
- R1: With mode_ser_i low the output source is par_word_i; with mode_ser_i high the source is the serial shift register, and par_word_i has no effect on the output while latch_en_i is high.
- R2: atten_o bit 5 weighs 16 dB, bit 4 8 dB, bit 3 4 dB, bit 2 2 dB, bit 1 1 dB and bit 0 0.5 dB; 6'b000000 is reference loss and 6'b111111 is 31.5 dB.
- R3: Each rising edge of ser_clk_i shifts ser_data_i into bit 0 while the older bits move up by one place, so the first of six bits sent lands in bit 5 (MSB first).
- R4: Shifting takes place whatever the level of latch_en_i; with latch_en_i high in serial mode, atten_o tracks the register after each shift.
- R5: While latch_en_i is low after reset, atten_o holds its value whatever the parallel pins or the serial pins do.
- R6: In parallel mode with latch_en_i held high, atten_o follows par_word_i within three system clock cycles.
- R7: In parallel mode, a high-then-low pulse on latch_en_i captures par_word_i, provided par_word_i is stable around the falling edge.
- R8: When reset is held in serial mode, atten_o is loaded from par_word_i.
- R9: When reset is held in parallel mode with latch_en_i low, pup_sel_i picks the word: 2'b00 gives 6'b000000, 2'b01 gives 6'b100000 (16 dB), 2'b10 gives 6'b010000 (8 dB) and 2'b11 gives 6'b111111.
- R10: When reset is held in parallel mode with latch_en_i high, pup_sel_i is ignored and atten_o is loaded from par_word_i.
- R11: ser_out_o shows bit 5 of the shift register, which is the bit the next shift pushes out to a chained device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every control pin |
| rst_n | input | 1 | Synchronous active-low reset; models power-up |
| mode_ser_i | input | 1 | Source select: 0 = parallel pins, 1 = serial register |
| par_word_i | input | 6 | Parallel attenuation word |
| pup_sel_i | input | 2 | Power-up select: bit 0 = 16 dB choice, bit 1 = 8 dB choice |
| ser_clk_i | input | 1 | Asynchronous serial shift clock |
| ser_data_i | input | 1 | Serial data, MSB first |
| latch_en_i | input | 1 | Output latch enable: high = transparent, low = hold |
| atten_o | output | 6 | Applied attenuation word in 0.5 dB steps |
| ser_out_o | output | 1 | Top register bit, for daisy-chaining |

## Verification
A serial shift and a transparent latch can act in the same cycle. This happens when the serial clock rises while the latch enable is high. The new register value must then reach atten_o right after the shift, and no older value may stick. The bench shifts a bit with the latch enable held high and expects the shifted word on the output. It also drives the parallel pins with a different value in the same window and expects that value to be ignored.

// File: rtl/atten_ctl_pkg.sv
// Shared widths and types for the step attenuator control interface.
// Assumes a 6-bit word with the MSB worth 16 dB.
package atten_ctl_pkg;
    localparam int WORD_W     = 6;
    localparam int SYNC_DEPTH = 2;
    localparam int PUP_W      = 2;

    typedef logic [WORD_W-1:0] atten_word_t;

    typedef enum logic {
        SRC_PAR = 1'b0,
        SRC_SER = 1'b1
    } atten_src_e;
endpackage

// File: rtl/atten_sync.sv
// Multi-stage synchroniser for one asynchronous control pin.
// Assumes the pin changes far more slowly than the system clock.
module atten_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    // Shift the pin value through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/atten_shift.sv
// Serial-in parallel-out register, MSB first, shifted on the sampled
// rising edge of the serial clock. Assumes clock and data share the same
// synchroniser depth, so they stay aligned.
module atten_shift #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_s_i,
    input  logic         sdat_s_i,
    output logic [W-1:0] sr_o,
    output logic         shift_o
);
    logic         sclk_d_q;
    logic [W-1:0] sr_q;

    // Remember the last serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d_q <= 1'b0;
        else        sclk_d_q <= sclk_s_i;
    end

    assign shift_o = sclk_s_i & ~sclk_d_q;

    // Shift new data into the low bit on each detected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (shift_o) sr_q <= {sr_q[W-2:0], sdat_s_i};
    end

    assign sr_o = sr_q;

    // R4: the register moves only on a detected serial edge.
    a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_o |=> $stable(sr_q));
endmodule

// File: rtl/atten_pwrup.sv
// Chooses the start word loaded while reset is held, from the mode,
// latch-enable and power-up select pins.
module atten_pwrup #(
    parameter int W = 6
) (
    input  logic         mode_ser_i,
    input  logic         le_i,
    input  logic [1:0]   pup_i,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] word_o
);
    localparam logic [W-1:0] SEL0_WORD = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] SEL1_WORD = {2'b01, {(W-2){1'b0}}};

    // Pick the parallel pins or one of four fixed start words.
    always_comb begin
        if (mode_ser_i || le_i) begin
            word_o = par_i;
        end else begin
            case (pup_i)
                2'b00:   word_o = '0;
                2'b01:   word_o = SEL0_WORD;
                2'b10:   word_o = SEL1_WORD;
                default: word_o = '1;
            endcase
        end
    end

    // R9: no select bits in parallel mode with latch low gives reference loss.
    always_comb begin
        if (!mode_ser_i && !le_i && pup_i == 2'b00)
            a_r9_zero_pick: assert (word_o == '0);
    end
endmodule

// File: rtl/atten_ctl_top.sv
// Control front end of a 6-bit step attenuator. It offers direct
// parallel, latched parallel and serial programming through one output
// latch. Asynchronous pins are sampled in the clk domain, and reset
// models power-up.
module atten_ctl_top
    import atten_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ser_i,
    input  logic [WORD_W-1:0] par_word_i,
    input  logic [PUP_W-1:0]  pup_sel_i,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              latch_en_i,
    output logic [WORD_W-1:0] atten_o,
    output logic              ser_out_o
);
    logic        sclk_s, sdat_s, le_s, shift_pulse;
    atten_word_t sr_word, pup_word, src_word, word_q;
    atten_src_e  src_sel;

    atten_sync #(.STAGES(SYNC_DEPTH)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d_i(ser_clk_i), .q_o(sclk_s));
    atten_sync #(.STAGES(SYNC_DEPTH)) u_sync_sdat (
        .clk(clk), .rst_n(rst_n), .d_i(ser_data_i), .q_o(sdat_s));
    atten_sync #(.STAGES(SYNC_DEPTH)) u_sync_le (
        .clk(clk), .rst_n(rst_n), .d_i(latch_en_i), .q_o(le_s));

    atten_shift #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_s_i(sclk_s), .sdat_s_i(sdat_s),
        .sr_o(sr_word), .shift_o(shift_pulse));

    atten_pwrup #(.W(WORD_W)) u_pwrup (
        .mode_ser_i(mode_ser_i), .le_i(latch_en_i), .pup_i(pup_sel_i),
        .par_i(par_word_i), .word_o(pup_word));

    // Select the source the latch would pass.
    always_comb begin
        src_sel  = atten_src_e'(mode_ser_i);
        src_word = (src_sel == SRC_SER) ? sr_word : par_word_i;
    end

    // Output latch: load the start word in reset, pass when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= pup_word;
        else if (le_s) word_q <= src_word;
    end

    assign atten_o   = word_q;
    assign ser_out_o = sr_word[WORD_W-1];

    // R5: the latch holds while the enable is low.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !le_s |=> $stable(atten_o));
    // R6: direct parallel passes the pins.
    a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (le_s && !mode_ser_i) |=> atten_o == $past(par_word_i));
    // R1: serial mode passes the shift register.
    a_r1_serial_src: assert property (@(posedge clk) disable iff (!rst_n)
        (le_s && mode_ser_i) |=> atten_o == $past(sr_word));
    // R8: serial power-up loads the parallel pins.
    a_r8_pwrup_serial: assert property (@(posedge clk)
        (!rst_n && mode_ser_i) |=> atten_o == $past(par_word_i));
    // R10: parallel power-up with the enable high ignores the select pins.
    a_r10_pwrup_direct: assert property (@(posedge clk)
        (!rst_n && !mode_ser_i && latch_en_i) |=> atten_o == $past(par_word_i));
    // R11: a shift moves the next bit to the chain output.
    a_r11_chain: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> ser_out_o == $past(sr_word[WORD_W-2]));
endmodule

// File: tb/atten_ctl_top_tb.sv
module atten_ctl_top_tb;
    localparam int PERIOD = 10;

    typedef struct {
        logic [5:0] exp_word;
        logic       exp_sdo;
        bit         is_sdo;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_ser = 1'b0;
    logic [5:0] par_word = '0;
    logic [1:0] pup_sel = '0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       latch_en = 1'b0;
    logic [5:0] atten;
    logic       ser_out;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    atten_ctl_top u_dut (
        .clk(clk), .rst_n(rst_n), .mode_ser_i(mode_ser), .par_word_i(par_word),
        .pup_sel_i(pup_sel), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
        .latch_en_i(latch_en), .atten_o(atten), .ser_out_o(ser_out));

    // Monitor: pop expected items and compare away from the active edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if (it.is_sdo) begin
                if (ser_out !== it.exp_sdo) begin
                    n_bad++;
                    $display("FAIL %s: ser_out=%b expected %b", it.tag, ser_out, it.exp_sdo);
                end
            end else if (atten !== it.exp_word) begin
                n_bad++;
                $display("FAIL %s: atten=%h expected %h", it.tag, atten, it.exp_word);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic exp_w(input logic [5:0] w, input string tag);
        item_t it;
        it.exp_word = w; it.exp_sdo = 1'b0; it.is_sdo = 1'b0; it.tag = tag;
        q.push_back(it);
        cyc(1);
    endtask

    task automatic exp_s(input logic b, input string tag);
        item_t it;
        it.exp_word = '0; it.exp_sdo = b; it.is_sdo = 1'b1; it.tag = tag;
        q.push_back(it);
        cyc(1);
    endtask

    task automatic power_up(input logic m, input logic le, input logic [1:0] p,
                            input logic [5:0] w);
        mode_ser = m; latch_en = le; pup_sel = p; par_word = w;
        rst_n = 1'b0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        cyc(3);
        ser_clk = 1'b1;
        cyc(4);
        ser_clk = 1'b0;
        cyc(4);
    endtask

    task automatic pulse_le();
        latch_en = 1'b1;
        cyc(5);
        latch_en = 1'b0;
        cyc(5);
    endtask

    initial begin
        // R9 and R2: four parallel start words chosen by the select pins
        power_up(1'b0, 1'b0, 2'b00, 6'h2A); exp_w(6'h00, "R9 pup00 reference loss");
        power_up(1'b0, 1'b0, 2'b10, 6'h2A); exp_w(6'h10, "R9 pup10 8dB");
        power_up(1'b0, 1'b0, 2'b01, 6'h2A); exp_w(6'h20, "R9 pup01 16dB");
        power_up(1'b0, 1'b0, 2'b11, 6'h00); exp_w(6'h3F, "R2 pup11 full scale 31.5dB");
        // R10: enable high at power-up ignores the select pins
        power_up(1'b0, 1'b1, 2'b11, 6'h2A); exp_w(6'h2A, "R10 direct power-up");
        // R6 and R1: direct parallel mode follows the pins
        par_word = 6'h15; cyc(5); exp_w(6'h15, "R6 direct follow");
        par_word = 6'h01; cyc(5); exp_w(6'h01, "R1 parallel source");
        // R5: enable low holds
        latch_en = 1'b0; cyc(5);
        par_word = 6'h3C; cyc(5); exp_w(6'h01, "R5 hold in parallel");
        // R7: pulse captures
        pulse_le(); exp_w(6'h3C, "R7 latched capture");
        par_word = 6'h07; cyc(5); exp_w(6'h3C, "R5 hold after capture");
        // R8: serial power-up takes the parallel pins
        power_up(1'b1, 1'b0, 2'b11, 6'h33); exp_w(6'h33, "R8 serial power-up");
        // R3: shift 101101 MSB first with the enable low; output unchanged
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        exp_w(6'h33, "R5 hold while shifting");
        exp_s(1'b1, "R11 chain bit after load");
        pulse_le(); exp_w(6'h2D, "R3 MSB-first word");
        send_bit(1'b0);
        exp_s(1'b0, "R11 chain bit after extra shift");
        exp_w(6'h2D, "R5 hold after extra shift");
        // R4 and R1: enable high, shift while parallel pins move
        latch_en = 1'b1; cyc(5);
        exp_w(6'h1A, "R4 transparent shows register");
        par_word = 6'h00;
        send_bit(1'b1); cyc(3);
        exp_w(6'h35, "R4 shift with enable high");
        par_word = 6'h3F; cyc(5);
        exp_w(6'h35, "R1 parallel ignored in serial");
        cyc(4);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done == 1'b1);
            begin
                #(PERIOD * 100000);
                n_bad++;
                $display("FAIL watchdog: done=0 expected 1");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule